// File: doc/BRIEF.md
# Wait-Mode Clock Gating Controller

This block moves a small processor core between normal running and a low-power wait state. It runs from a free-running oscillator clock and produces a master clock at half the oscillator rate. From that master clock it derives a CPU clock that is gated in wait, and one clock for each on-chip peripheral. Every derived clock is produced from a register, and a gate only opens or closes at a master-period boundary, so a running clock never shows a shortened pulse.

The CPU decoder requests wait mode with a wait-for-interrupt pulse. On entry the block opens the two-bit interrupt-mask field so that every interrupt can wake the core. The CPU clock then stops, while the master clock and the peripheral clocks keep running. There are two ways out of wait. A pending interrupt restarts the CPU at once, raises a service indication and closes the mask for the handler. A reset request first holds the CPU for a programmable number of master periods and then raises a reset-vector fetch indication. If a reset request and an interrupt arrive together, the reset request wins.

Software can turn any peripheral clock off through an enable register, whatever the power mode. In run mode it can also write the mask field.

Top module: `wait_clkgate_ctrl`

## Requirements
- R1: After `rst` the block is in run mode. `cpu_clk_en_o` is 1, all peripheral enables are 1, `imask_o` is 2'b11, and `wake_irq_o` and `fetch_rst_o` are 0.
- R2: `mclk_o` toggles on every oscillator cycle, so it runs at half the oscillator frequency. `cpu_clk_o` and each `pclk_o` bit are high only while `mclk_o` is high.
- R3: Only a `wfi_req` pulse, which may be one oscillator cycle long, enters wait mode. Wait is entered at the next master-period boundary. An interrupt pending in run mode does not stop the CPU clock and does not raise `wake_irq_o`.
- R4: In wait mode `cpu_clk_o` stays low and `cpu_clk_en_o` is 0. `mclk_o` and every enabled peripheral clock keep toggling.
- R5: Entering wait sets `imask_o` to 2'b00. A `mask_wr` while in wait has no effect.
- R6: In wait mode, any `irq_pend` bit at 1 returns the block to run mode at the next master boundary. `cpu_clk_en_o` becomes 1, `imask_o` becomes 2'b11, and `wake_irq_o` is high for exactly one master period (two oscillator cycles).
- R7: A `rst_req` pulse, in run or in wait, drops `cpu_clk_en_o` at a master boundary and holds it low for exactly `RST_DLY_CYC` master periods. `cpu_clk_en_o` then returns to 1 together with `fetch_rst_o`, which stays high for one master period.
- R8: When `rst_req` and an interrupt are seen at the same master boundary in wait, the block takes the reset path: `wake_irq_o` stays 0 and `fetch_rst_o` follows the delay.
- R9: Bit i of the peripheral enable register, written through `pen_wr`/`pen_wdata`, gates `pclk_o[i]`: at 1 the clock follows `mclk_o`, at 0 it is held low. This holds in run and in wait mode.
- R10: In run mode, `mask_wr` loads `mask_wdata` into `imask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse from the CPU decoder |
| rst_req | input | 1 | Reset request pulse that wakes through the delay path |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| pen_wr | input | 1 | Write strobe for the peripheral enable register |
| pen_wdata | input | N_PERIPH | New peripheral enable bits |
| mask_wr | input | 1 | Write strobe for the interrupt-mask field |
| mask_wdata | input | 2 | New interrupt-mask value |
| mclk_o | output | 1 | Master clock, oscillator divided by 2 |
| cpu_clk_o | output | 1 | Gated CPU clock |
| cpu_clk_en_o | output | 1 | CPU clock enable currently applied |
| pclk_o | output | N_PERIPH | Gated per-peripheral clocks |
| imask_o | output | 2 | Interrupt-mask field |
| wake_irq_o | output | 1 | Service-interrupt indication, one master period |
| fetch_rst_o | output | 1 | Fetch-reset-vector indication, one master period |

## Verification
The wait state is reached from a one-cycle `wfi_req` pulse. It is left three ways: by an interrupt alone, by a reset request alone, and by both together. Together these separate the service path from the delayed reset path and show that reset has priority. An interrupt held in run mode shows that only the wait request stops the CPU. A mask write during wait shows that the opened mask is held. Pulse counts over fixed windows, taken in both modes with a mixed peripheral enable pattern, separate the gated CPU clock from the free-running peripheral clocks. The reset delay is measured from run mode in oscillator cycles and compared with exactly twice `RST_DLY_CYC`.

// File: rtl/wcg_pkg.sv
package wcg_pkg;
  localparam int IMASK_W = 2;
  localparam logic [IMASK_W-1:0] MASK_OPEN = '0;
  localparam logic [IMASK_W-1:0] MASK_SHUT = '1;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RDLY = 2'd2
  } wcg_state_e;
endpackage

// File: rtl/wcg_divider.sv
module wcg_divider (
  input  logic clk,
  input  logic rst,
  output logic ph,
  output logic tick
);
  // ph is the master clock; a master period ends on the edge where ph is 1
  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign tick = ph;
endmodule

// File: rtl/wcg_mode_fsm.sv
module wcg_mode_fsm
  import wcg_pkg::*;
#(
  parameter int RST_DLY_CYC = 256,
  parameter int N_IRQ       = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wfi_req,
  input  logic               rst_req,
  input  logic [N_IRQ-1:0]   irq_pend,
  input  logic               mask_wr,
  input  logic [IMASK_W-1:0] mask_wdata,
  output logic               cpu_en,
  output logic [IMASK_W-1:0] imask,
  output logic               wake_irq,
  output logic               fetch_rst
);
  localparam int CW = (RST_DLY_CYC > 1) ? $clog2(RST_DLY_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_DLY_CYC - 1);

  wcg_state_e st;
  logic [CW-1:0] cnt;
  logic wfi_seen, rreq_seen;
  logic wfi_evt, rst_evt, irq_any;

  // request pulses are held until the next master boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      wfi_seen  <= 1'b0;
      rreq_seen <= 1'b0;
    end else if (tick) begin
      wfi_seen  <= 1'b0;
      rreq_seen <= 1'b0;
    end else begin
      wfi_seen  <= wfi_seen | wfi_req;
      rreq_seen <= rreq_seen | rst_req;
    end
  end

  always_comb begin
    wfi_evt = wfi_seen | wfi_req;
    rst_evt = rreq_seen | rst_req;
    irq_any = |irq_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      cnt       <= '0;
      cpu_en    <= 1'b1;
      imask     <= MASK_SHUT;
      wake_irq  <= 1'b0;
      fetch_rst <= 1'b0;
    end else if (tick) begin
      wake_irq  <= 1'b0;
      fetch_rst <= 1'b0;
      if (rst_evt) begin
        st     <= ST_RDLY;
        cnt    <= '0;
        cpu_en <= 1'b0;
      end else begin
        unique case (st)
          ST_RUN: begin
            if (wfi_evt) begin
              st     <= ST_WAIT;
              cpu_en <= 1'b0;
              imask  <= MASK_OPEN;
            end else if (mask_wr) begin
              imask <= mask_wdata;
            end
          end
          ST_WAIT: begin
            if (irq_any) begin
              st       <= ST_RUN;
              cpu_en   <= 1'b1;
              imask    <= MASK_SHUT;
              wake_irq <= 1'b1;
            end
          end
          ST_RDLY: begin
            if (cnt == CNT_LAST) begin
              st        <= ST_RUN;
              cpu_en    <= 1'b1;
              imask     <= MASK_SHUT;
              fetch_rst <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_RUN;
        endcase
      end
    end else if (mask_wr && st == ST_RUN) begin
      imask <= mask_wdata;
    end
  end

  assert_wait_cpu_off_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> !cpu_en);
  assert_wait_mask_open_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> (imask == MASK_OPEN));
  assert_wake_shuts_mask_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq) |-> (imask == MASK_SHUT && cpu_en));
  assert_dly_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDLY) |-> (cnt <= CNT_LAST));
  assert_fetch_after_dly_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_rst) |-> ($past(st) == ST_RDLY));
  assert_rst_first_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && rst_evt) |=> (st == ST_RDLY && !wake_irq));
  assert_single_wake_R8: assert property (@(posedge clk) disable iff (rst)
    fetch_rst |-> !wake_irq);
endmodule

// File: rtl/wcg_clk_gates.sv
module wcg_clk_gates #(
  parameter int N_PERIPH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                ph,
  input  logic                cpu_en,
  input  logic                pen_wr,
  input  logic [N_PERIPH-1:0] pen_wdata,
  output logic                cpu_clk,
  output logic [N_PERIPH-1:0] pclk
);
  logic [N_PERIPH-1:0] pen_reg, pen_act;

  // software value, applied only at a master boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      pen_reg <= '1;
      pen_act <= '1;
    end else begin
      if (pen_wr) pen_reg <= pen_wdata;
      if (tick)   pen_act <= pen_reg;
    end
  end

  // enables change on the edge that drives every gated output low
  always_ff @(posedge clk) begin
    if (rst) cpu_clk <= 1'b0;
    else     cpu_clk <= ~ph & cpu_en;
  end

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_pgate
    always_ff @(posedge clk) begin
      if (rst) pclk[i] <= 1'b0;
      else     pclk[i] <= ~ph & pen_act[i];
    end

    assert_pgate_off_R9: assert property (@(posedge clk) disable iff (rst)
      !pen_act[i] |=> !pclk[i]);
  end

  assert_cpu_gate_off_R4: assert property (@(posedge clk) disable iff (rst)
    !cpu_en |=> !cpu_clk);
endmodule

// File: rtl/wait_clkgate_ctrl.sv
module wait_clkgate_ctrl
  import wcg_pkg::*;
#(
  parameter int RST_DLY_CYC = 256,
  parameter int N_IRQ       = 3,
  parameter int N_PERIPH    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wfi_req,
  input  logic                rst_req,
  input  logic [N_IRQ-1:0]    irq_pend,
  input  logic                pen_wr,
  input  logic [N_PERIPH-1:0] pen_wdata,
  input  logic                mask_wr,
  input  logic [1:0]          mask_wdata,
  output logic                mclk_o,
  output logic                cpu_clk_o,
  output logic                cpu_clk_en_o,
  output logic [N_PERIPH-1:0] pclk_o,
  output logic [1:0]          imask_o,
  output logic                wake_irq_o,
  output logic                fetch_rst_o
);
  logic ph, tick, cpu_en;

  wcg_divider u_div (
    .clk  (clk),
    .rst  (rst),
    .ph   (ph),
    .tick (tick)
  );

  wcg_mode_fsm #(
    .RST_DLY_CYC (RST_DLY_CYC),
    .N_IRQ       (N_IRQ)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .wfi_req    (wfi_req),
    .rst_req    (rst_req),
    .irq_pend   (irq_pend),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .cpu_en     (cpu_en),
    .imask      (imask_o),
    .wake_irq   (wake_irq_o),
    .fetch_rst  (fetch_rst_o)
  );

  wcg_clk_gates #(
    .N_PERIPH (N_PERIPH)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ph        (ph),
    .cpu_en    (cpu_en),
    .pen_wr    (pen_wr),
    .pen_wdata (pen_wdata),
    .cpu_clk   (cpu_clk_o),
    .pclk      (pclk_o)
  );

  assign mclk_o       = ph;
  assign cpu_clk_en_o = cpu_en;

  assert_mclk_fall_R2: assert property (@(posedge clk) disable iff (rst)
    mclk_o |=> !mclk_o);
  assert_mclk_rise_R2: assert property (@(posedge clk) disable iff (rst)
    !mclk_o |=> mclk_o);
  assert_cpu_in_master_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_o |-> mclk_o);
  assert_pclk_in_master_R2: assert property (@(posedge clk) disable iff (rst)
    (|pclk_o) |-> mclk_o);
endmodule

// File: tb/wait_clkgate_ctrl_tb.sv
module wait_clkgate_ctrl_tb;
  localparam int DLY = 256;
  localparam int NI  = 3;
  localparam int NP  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfi_req = 1'b0, rst_req = 1'b0, pen_wr = 1'b0, mask_wr = 1'b0;
  logic [NI-1:0] irq_pend = '0;
  logic [NP-1:0] pen_wdata = '0;
  logic [1:0] mask_wdata = '0;
  logic mclk_o, cpu_clk_o, cpu_clk_en_o, wake_irq_o, fetch_rst_o;
  logic [NP-1:0] pclk_o;
  logic [1:0] imask_o;

  int checks = 0, fails = 0;
  int c_cpu, c_tog;
  int c_p [NP];

  always #2.5 clk = ~clk;

  wait_clkgate_ctrl #(.RST_DLY_CYC(DLY), .N_IRQ(NI), .N_PERIPH(NP)) u_dut (
    .clk(clk), .rst(rst), .wfi_req(wfi_req), .rst_req(rst_req),
    .irq_pend(irq_pend), .pen_wr(pen_wr), .pen_wdata(pen_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mclk_o(mclk_o),
    .cpu_clk_o(cpu_clk_o), .cpu_clk_en_o(cpu_clk_en_o), .pclk_o(pclk_o),
    .imask_o(imask_o), .wake_irq_o(wake_irq_o), .fetch_rst_o(fetch_rst_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic count_win(input int n);
    logic prev;
    c_cpu = 0; c_tog = 0;
    for (int i = 0; i < NP; i++) c_p[i] = 0;
    prev = mclk_o;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cpu_clk_o) c_cpu++;
      if (mclk_o != prev) c_tog++;
      prev = mclk_o;
      for (int i = 0; i < NP; i++) if (pclk_o[i]) c_p[i]++;
    end
  endtask

  task automatic go_wait();
    @(negedge clk); wfi_req = 1'b1;
    @(negedge clk); wfi_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_clk_en_o == 1'b1, "R1", "cpu enable after reset", cpu_clk_en_o, 1);
    chk(imask_o == 2'b11, "R1", "mask after reset", imask_o, 3);
    chk(wake_irq_o == 1'b0 && fetch_rst_o == 1'b0, "R1", "wake flags after reset",
        wake_irq_o + fetch_rst_o, 0);
    count_win(16);
    for (int i = 0; i < NP; i++)
      chk(c_p[i] == 8, "R1", "peripheral clock on after reset", c_p[i], 8);
  endtask

  task automatic t_divider();
    count_win(16);
    chk(c_tog == 16, "R2", "master clock toggles", c_tog, 16);
    chk(c_cpu == 8, "R2", "cpu clock high half the time", c_cpu, 8);
  endtask

  task automatic t_irq_in_run();
    int wk = 0;
    @(negedge clk); irq_pend = 3'b010;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (wake_irq_o) wk++;
    end
    chk(cpu_clk_en_o == 1'b1, "R3", "irq in run keeps cpu", cpu_clk_en_o, 1);
    chk(wk == 0, "R3", "no wake indication in run", wk, 0);
    count_win(8);
    chk(c_cpu == 4, "R3", "cpu clock still running", c_cpu, 4);
    irq_pend = '0;
  endtask

  task automatic t_wfi();
    go_wait();
    chk(cpu_clk_en_o == 1'b0, "R3", "wfi pulse enters wait", cpu_clk_en_o, 0);
    chk(imask_o == 2'b00, "R5", "mask opened in wait", imask_o, 0);
    count_win(16);
    chk(c_cpu == 0, "R4", "cpu clock stopped", c_cpu, 0);
    chk(c_tog == 16, "R4", "master clock runs in wait", c_tog, 16);
    chk(c_p[0] == 8, "R4", "peripheral clock runs in wait", c_p[0], 8);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = 2'b10;
    @(negedge clk); mask_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(imask_o == 2'b00, "R5", "mask write ignored in wait", imask_o, 0);
  endtask

  task automatic t_irq_wake();
    int t = 0, w = 0;
    @(negedge clk); irq_pend[NI-1] = 1'b1;
    while (!wake_irq_o && t < 8) begin @(negedge clk); t++; end
    chk(wake_irq_o == 1'b1, "R6", "wake indication raised", wake_irq_o, 1);
    chk(imask_o == 2'b11, "R6", "mask shut for handler", imask_o, 3);
    chk(cpu_clk_en_o == 1'b1, "R6", "cpu enable restored", cpu_clk_en_o, 1);
    while (wake_irq_o && w < 8) begin w++; @(negedge clk); end
    chk(w == 2, "R6", "wake indication width", w, 2);
    irq_pend = '0;
    count_win(16);
    chk(c_cpu == 8, "R6", "cpu clock resumed", c_cpu, 8);
  endtask

  task automatic t_mask_wr();
    @(negedge clk); mask_wr = 1'b1; mask_wdata = 2'b01;
    @(negedge clk); mask_wr = 1'b0;
    @(negedge clk);
    chk(imask_o == 2'b01, "R10", "mask write in run", imask_o, 1);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = 2'b11;
    @(negedge clk); mask_wr = 1'b0;
    @(negedge clk);
    chk(imask_o == 2'b11, "R10", "mask write back", imask_o, 3);
  endtask

  task automatic t_rst_from_run();
    int t = 0, d = 0, w = 0;
    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    while (cpu_clk_en_o && t < 8) begin @(negedge clk); t++; end
    chk(cpu_clk_en_o == 1'b0, "R7", "cpu held in delay", cpu_clk_en_o, 0);
    while (!fetch_rst_o && d < 4 * DLY) begin @(negedge clk); d++; end
    chk(d == 2 * DLY, "R7", "reset delay in oscillator cycles", d, 2 * DLY);
    chk(cpu_clk_en_o == 1'b1, "R7", "cpu released with fetch", cpu_clk_en_o, 1);
    while (fetch_rst_o && w < 8) begin w++; @(negedge clk); end
    chk(w == 2, "R7", "fetch indication width", w, 2);
  endtask

  task automatic t_rst_from_wait();
    int d = 0, hi = 0;
    go_wait();
    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    while (!fetch_rst_o && d < 4 * DLY) begin
      @(negedge clk); d++;
      if (cpu_clk_o) hi++;
    end
    chk(fetch_rst_o == 1'b1, "R7", "fetch after reset in wait", fetch_rst_o, 1);
    chk(d >= 2 * DLY - 2 && d <= 2 * DLY + 2, "R7", "delay from wait", d, 2 * DLY);
    chk(hi == 0, "R7", "cpu clock quiet during delay", hi, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_priority();
    int d = 0, wk = 0;
    go_wait();
    @(negedge clk); rst_req = 1'b1; irq_pend = 3'b001;
    @(negedge clk); rst_req = 1'b0;
    while (!fetch_rst_o && d < 4 * DLY) begin
      @(negedge clk); d++;
      if (wake_irq_o) wk++;
      if (d == 10) irq_pend = '0;
    end
    irq_pend = '0;
    chk(wk == 0, "R8", "no interrupt wake when reset coincides", wk, 0);
    chk(fetch_rst_o == 1'b1, "R8", "reset path taken", fetch_rst_o, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_periph();
    @(negedge clk); pen_wr = 1'b1; pen_wdata = 4'b0101;
    @(negedge clk); pen_wr = 1'b0;
    repeat (4) @(negedge clk);
    count_win(16);
    chk(c_p[0] == 8 && c_p[2] == 8, "R9", "enabled peripheral clocks", c_p[0] + c_p[2], 16);
    chk(c_p[1] == 0 && c_p[3] == 0, "R9", "disabled peripheral clocks", c_p[1] + c_p[3], 0);
    go_wait();
    count_win(16);
    chk(c_p[2] == 8 && c_p[3] == 0, "R9", "enables hold in wait", c_p[2] + c_p[3], 8);
    @(negedge clk); irq_pend = 3'b001;
    repeat (6) @(negedge clk);
    irq_pend = '0;
    @(negedge clk); pen_wr = 1'b1; pen_wdata = '1;
    @(negedge clk); pen_wr = 1'b0;
    repeat (4) @(negedge clk);
    count_win(16);
    chk(c_p[1] == 8, "R9", "peripheral re-enabled", c_p[1], 8);
  endtask

  initial begin
    t_reset();
    t_divider();
    t_irq_in_run();
    t_wfi();
    t_irq_wake();
    t_mask_wr();
    t_rst_from_run();
    t_rst_from_wait();
    t_priority();
    t_periph();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule